// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This peripheral watches over a processor. A 16-bit up-counter advances on one of two clock-enable inputs. It expires when a chosen counter bit rises. In watchdog mode an expiry asks for a system reset, so software must clear the counter often enough to keep the system alive. In interval mode the same expiry sets an interrupt flag, and the interrupt output is raised only if its enable bit is set. This gives a periodic tick source.

Software reaches the block through a two-register bus. Address 0 is the control register. Every write to it must carry the key byte 0x5A in bits 15:8. A write with any other key is discarded and requests a reset. Address 1 holds the interval flag and the interrupt enable. The block also stores the settings for an external NMI pin (edge polarity and enable) and drives them out. The pin logic that uses them lives outside this block.

Top module: `wdt_guard`

## Requirements
- R1: A write to address 0 whose bits 15:8 differ from 0x5A leaves the control bits unchanged. It drives `sys_rst_req` high for exactly the one cycle after the write edge.
- R2: Reading address 0 returns 0x69 in bits 15:8. Bits 7:0 return the stored fields: bit 7 hold, bit 6 NMI falling edge, bit 5 NMI enable, bit 4 mode (1 = interval), bit 3 counter clear, bit 2 source, bits 1:0 interval select. A keyed write stores bits 7:0.
- R3: A keyed write with bit 3 set zeroes the counter. Bit 3 always reads back 0.
- R4: While hold is 1, the counter does not advance and no expiry occurs.
- R5: In watchdog mode (bit 4 = 0), an expiry drives `sys_rst_req` high for a single cycle and leaves the interval flag untouched.
- R6: In interval mode (bit 4 = 1), an expiry sets the interval flag and does not drive `sys_rst_req`.
- R7: Counted from a clear, the number of selected ticks up to and including the expiring tick is 32768 for select 00, 8192 for 01, 512 for 10 and 64 for 11. The expiry restarts the counter, so the next expiry comes after the same number of ticks.
- R8: Source 0 advances the counter on `tick_a` only. Source 1 advances it on `tick_b` only.
- R9: Address 1 reads {14'b0, enable, flag}, with the flag in bit 0 and the enable in bit 1. A write there loads the enable from bit 1 and clears the flag when bit 0 is 0. `irq` is high exactly when both the flag and the enable are set.
- R10: `nmi_edge_fall` and `nmi_pin_en` follow control bits 6 and 5.
- R11: After reset, address 0 reads 0x6900, address 1 reads 0, the counter is zero, and `sys_rst_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 flag/enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| tick_a | input | 1 | Count enable, source 0 |
| tick_b | input | 1 | Count enable, source 1 |
| sys_rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | Interval interrupt |
| nmi_edge_fall | output | 1 | NMI edge polarity, 1 = falling |
| nmi_pin_en | output | 1 | NMI pin function enable |

## Verification
The assertions check several rules on every cycle: a bad key is always followed by a reset request, a held counter never moves, an expiry always restarts the counter, a keyed clear always zeroes it, and the flag rises only in interval mode. Only the bench's scenarios can show that the measured tick counts match each interval select under both sources, and that the wrong source has no effect. The same holds for reset pulse length, the read-back encodings, and the interrupt gating.

// File: rtl/wdt_guard.sv
`timescale 1ns/1ps
module wdt_guard #(
  parameter int         CNT_W  = 16,
  parameter logic [7:0] KEY_WR = 8'h5A,
  parameter logic [7:0] KEY_RD = 8'h69,
  parameter int         TAP_0  = 15,
  parameter int         TAP_1  = 13,
  parameter int         TAP_2  = 9,
  parameter int         TAP_3  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        tick_a,
  input  logic        tick_b,
  output logic        sys_rst_req,
  output logic        irq,
  output logic        nmi_edge_fall,
  output logic        nmi_pin_en
);
  logic             hold_q, fall_q, nmien_q, mode_q, src_q;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             flag_q, ie_q, rst_q;
  logic             ctl_wr, ctl_good, ctl_bad, flg_wr, tick, step, tap_bit, expire;

  assign ctl_wr   = bus_wr && !bus_addr;
  assign ctl_good = ctl_wr && (bus_wdata[15:8] == KEY_WR);
  assign ctl_bad  = ctl_wr && (bus_wdata[15:8] != KEY_WR);
  assign flg_wr   = bus_wr && bus_addr;
  assign tick     = src_q ? tick_b : tick_a;
  assign step     = tick && !hold_q;
  assign cnt_nx   = cnt_q + 1'b1;

  always_comb begin
    case (sel_q)
      2'd0:    tap_bit = cnt_nx[TAP_0];
      2'd1:    tap_bit = cnt_nx[TAP_1];
      2'd2:    tap_bit = cnt_nx[TAP_2];
      default: tap_bit = cnt_nx[TAP_3];
    endcase
  end
  assign expire = step && tap_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {hold_q, fall_q, nmien_q, mode_q, src_q} <= '0;
      sel_q <= '0;
    end else if (ctl_good) begin
      {hold_q, fall_q, nmien_q, mode_q} <= bus_wdata[7:4];
      src_q <= bus_wdata[2];
      sel_q <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (ctl_good && bus_wdata[3]) cnt_q <= '0;
    else if (expire)                 cnt_q <= '0;
    else if (step)                   cnt_q <= cnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= ctl_bad || (expire && !mode_q);
      if (expire && mode_q)            flag_q <= 1'b1;
      else if (flg_wr && !bus_wdata[0]) flag_q <= 1'b0;
      if (flg_wr) ie_q <= bus_wdata[1];
    end
  end

  assign bus_rdata     = bus_addr ? {14'd0, ie_q, flag_q}
                                  : {KEY_RD, hold_q, fall_q, nmien_q, mode_q, 1'b0, src_q, sel_q};
  assign sys_rst_req   = rst_q;
  assign irq           = flag_q && ie_q;
  assign nmi_edge_fall = fall_q;
  assign nmi_pin_en    = nmien_q;

  p_badkey_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bad |=> sys_rst_req);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_good && bus_wdata[3]) |=> (cnt_q == '0));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !ctl_good) |=> $stable(cnt_q));
  p_flag_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !mode_q) |=> !flag_q);
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));
  p_wd_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mode_q) |=> sys_rst_req);
endmodule

// File: tb/wdt_guard_tb_top.sv
`timescale 1ns/1ps
module wdt_guard_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_addr = 1, tick_a = 0, tick_b = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic sys_rst_req, irq, nmi_edge_fall, nmi_pin_en;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wdt_guard dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_a(tick_a), .tick_b(tick_b),
    .sys_rst_req(sys_rst_req), .irq(irq), .nmi_edge_fall(nmi_edge_fall), .nmi_pin_en(nmi_pin_en));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0; bus_addr = 1;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
    bus_addr = 1;
  endtask

  // Returns the tick cycle on which the flag or reset request appeared, 0 if none.
  task automatic run(input logic ta, input logic tb, input int maxc, output int n, output bit was_rst);
    n = 0; was_rst = 0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk); tick_a = ta; tick_b = tb;
      @(posedge clk); #1;
      if (sys_rst_req || bus_rdata[0]) begin
        n = i; was_rst = sys_rst_req; break;
      end
    end
    @(negedge clk); tick_a = 0; tick_b = 0;
  endtask

  initial begin
    #1_520_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n;
    bit r;
    int len[4] = '{32768, 8192, 512, 64};
    repeat (3) @(posedge clk);
    rst_n = 1;
    #1;
    rd(0, d); chk("R11 ctrl after reset", d, 16'h6900);
    rd(1, d); chk("R11 flag after reset", d, 0);
    chk("R11 rst_req/irq low", {sys_rst_req, irq}, 0);

    // R7/R6: interval mode, every select, source a
    for (int s = 0; s < 4; s++) begin
      wr(0, {8'h5A, 8'b0001_1000 | 8'(s)});
      wr(1, 16'h0000);
      run(1, 0, 40000, n, r);
      chk($sformatf("R7 interval length sel=%0d", s), n, len[s]);
      chk("R6 no reset request in interval mode", r, 0);
    end
    // R7 restart: second interval equally long
    wr(1, 16'h0000);
    run(1, 0, 200, n, r);
    chk("R7 restart after expiry", n, 64);

    // R9 irq gating
    rd(1, d); chk("R9 flag read", d, 1);
    chk("R9 irq low without enable", irq, 0);
    wr(1, 16'h0003);
    chk("R9 irq with enable", irq, 1);
    rd(1, d); chk("R9 read enable+flag", d, 3);
    wr(1, 16'h0002);
    chk("R9 flag cleared, irq low", {irq, bus_rdata[0]}, 0);
    wr(1, 16'h0000);

    // R5/R7: watchdog mode, every select
    for (int s = 0; s < 4; s++) begin
      wr(0, {8'h5A, 8'b0000_1000 | 8'(s)});
      run(1, 0, 40000, n, r);
      chk($sformatf("R5 watchdog length sel=%0d", s), n, len[s]);
      chk("R5 reset request raised", r, 1);
      @(posedge clk); #1;
      chk("R5 single-cycle request", sys_rst_req, 0);
      rd(1, d); chk("R5 flag untouched", d[0], 0);
    end

    // R8 source select
    wr(0, {8'h5A, 8'b0001_1111});
    run(1, 0, 150, n, r); chk("R8 source 1 ignores tick_a", n, 0);
    run(0, 1, 150, n, r); chk("R8 source 1 counts tick_b", n, 64);
    wr(1, 16'h0000);
    wr(0, {8'h5A, 8'b0001_1011});
    run(0, 1, 150, n, r); chk("R8 source 0 ignores tick_b", n, 0);
    run(1, 0, 150, n, r); chk("R8 source 0 counts tick_a", n, 64);
    wr(1, 16'h0000);

    // R3 clear mid-interval; bit 3 reads 0
    wr(0, {8'h5A, 8'b0001_1011});
    run(1, 0, 40, n, r);
    wr(0, {8'h5A, 8'b0001_1011});
    rd(0, d); chk("R3 clear bit reads 0", d, 16'h6913);
    run(1, 0, 150, n, r); chk("R3 full interval after clear", n, 64);
    wr(1, 16'h0000);

    // R4 hold in watchdog mode
    wr(0, {8'h5A, 8'b1000_1011});
    run(1, 0, 200, n, r); chk("R4 hold suppresses expiry", n, 0);
    wr(0, {8'h5A, 8'b0000_0011});
    run(1, 0, 150, n, r); chk("R4 counter did not move under hold", n, 64);

    // R1 bad key
    wr(0, {8'h5A, 8'b0001_0010});
    @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = 16'hA5FF;
    @(posedge clk); #1; bus_wr = 0; bus_addr = 1;
    chk("R1 bad key requests reset", sys_rst_req, 1);
    @(posedge clk); #1;
    chk("R1 request lasts one cycle", sys_rst_req, 0);
    rd(0, d); chk("R1 control unchanged", d, 16'h6912);

    // R10/R2 NMI fields and read-back
    wr(0, {8'h5A, 8'b0110_0100});
    chk("R10 nmi outputs", {nmi_edge_fall, nmi_pin_en}, 2'b11);
    rd(0, d); chk("R2 read-back", d, 16'h6964);
    wr(0, {8'h5A, 8'b0010_0001});
    chk("R10 nmi rising edge", {nmi_edge_fall, nmi_pin_en}, 2'b01);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule